// File: doc/BRIEF.md
# Pre-Adder Multiply-Accumulate Slice

This block is a pipelined signed arithmetic slice. Two operands, A and D, are summed by a pre-adder. The sum is multiplied by a third operand, B. A post-adder then either combines the product with a fourth operand, C, or folds it into the slice's own output register to accumulate. The operation is picked by one small select port, so the caller never drives separate mode bits for the pre-adder, the multiplier and the post-adder.

Every register in the slice shares one synchronous active-low clear and one clock enable. The select code travels down the pipeline beside the operands. Every path from an input to the output therefore takes the same three enabled clock edges, and the select may change on every cycle without pairing one operation with another cycle's operands. All operands are two's-complement signed values. The 48-bit result wraps modulo 2^48.

Top module: `preadd_mac_slice`

## Requirements
- R1: With `op_sel` = 0 captured on an enabled edge, the output after the third enabled edge counted from that one is B×(A+D)+C, using the operands captured on that same edge.
- R2: With `op_sel` = 1, the result is the registered output value held just before that third edge plus B×(A+D), which accumulates.
- R3: With `op_sel` = 2, the result is B×(A+D) alone.
- R4: With `op_sel` = 3, the result is C−B×(A+D).
- R5: A and D are 18-bit signed values that are sign-extended to 19 bits before the pre-add, so the sum never overflows. This holds even when both inputs are at the most negative or the most positive value.
- R6: `op_sel` takes the same three-edge latency as the operands, so changing the select on every cycle never pairs an operation with the wrong operands.
- R7: An edge with `rst_n` low zeroes the output and every pipeline register, whatever `ce` is. The next two enabled edges after the clear then give an output of 0, because the flushed stages hold the value 0 with select code 0.
- R8: On an edge with `rst_n` high and `ce` low, every register holds its value, so the output and the accumulator state stay unchanged.
- R9: B is 18-bit signed and C is 48-bit signed. The product is sign-extended to 48 bits, and sums that pass the 48-bit range wrap modulo 2^48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst_n | input | 1 | Synchronous clear, active low, shared by all registers |
| ce | input | 1 | Clock enable shared by all registers |
| op_sel | input | 2 | Operation code: 0 = B×(A+D)+C, 1 = accumulate, 2 = B×(A+D), 3 = C−B×(A+D) |
| a_in | input | 18 | Signed pre-adder operand A |
| d_in | input | 18 | Signed pre-adder operand D |
| b_in | input | 18 | Signed multiplier operand B |
| c_in | input | 48 | Signed post-adder operand C |
| p_out | output | 48 | Signed registered result P |

## Verification
The arithmetic assertions assume three back-to-back edges with `ce` high and `rst_n` high, so they check a result only after a counter in the checker has seen that unbroken enabled run. Any stall or clear in the window suspends the check rather than shifting it. The stimulus keeps every input driven to a known value from time zero and holds `ce` high through the opening clear, so no register is ever unknown. It mixes bursts of random select codes, random `ce` drops and rare mid-run clears, so that the enabled-run condition is met often and broken often.

// File: rtl/mac_pkg.sv
// Package mac_pkg
// Shared operation codes and post-adder control types for the pre-adder
// multiply-accumulate slice. Assumes a 2-bit operation select.
package mac_pkg;

    typedef enum logic [1:0] {
        OP_MAC_C   = 2'd0,
        OP_ACCUM   = 2'd1,
        OP_MUL     = 2'd2,
        OP_C_MINUS = 2'd3
    } mac_op_e;

    typedef enum logic [1:0] {
        ADDEND_ZERO = 2'd0,
        ADDEND_C    = 2'd1,
        ADDEND_P    = 2'd2
    } addend_e;

    typedef struct packed {
        addend_e addend;
        logic    neg_prod;
    } post_ctrl_t;

    localparam post_ctrl_t POST_CTRL_RESET = '{addend: ADDEND_C, neg_prod: 1'b0};

    // Translate an operation code into post-adder steering.
    function automatic post_ctrl_t decode_op(input logic [1:0] op);
        post_ctrl_t c;
        unique case (mac_op_e'(op))
            OP_MAC_C:   c = '{addend: ADDEND_C,    neg_prod: 1'b0};
            OP_ACCUM:   c = '{addend: ADDEND_P,    neg_prod: 1'b0};
            OP_MUL:     c = '{addend: ADDEND_ZERO, neg_prod: 1'b0};
            OP_C_MINUS: c = '{addend: ADDEND_C,    neg_prod: 1'b1};
            default:    c = POST_CTRL_RESET;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mac_in_stage.sv
// Module mac_in_stage
// First pipeline stage: registers every operand and the operation code.
// Assumes a synchronous active-low clear that overrides the clock enable.
module mac_in_stage #(
    parameter int A_W = 18,
    parameter int B_W = 18,
    parameter int C_W = 48
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ce,
    input  logic [1:0]            op_in,
    input  logic signed [A_W-1:0] a_in,
    input  logic signed [A_W-1:0] d_in,
    input  logic signed [B_W-1:0] b_in,
    input  logic signed [C_W-1:0] c_in,
    output logic [1:0]            op_q,
    output logic signed [A_W-1:0] a_q,
    output logic signed [A_W-1:0] d_q,
    output logic signed [B_W-1:0] b_q,
    output logic signed [C_W-1:0] c_q
);

    // Capture the operands and the select together on each enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= '0;
            a_q  <= '0;
            d_q  <= '0;
            b_q  <= '0;
            c_q  <= '0;
        end else if (ce) begin
            op_q <= op_in;
            a_q  <= a_in;
            d_q  <= d_in;
            b_q  <= b_in;
            c_q  <= c_in;
        end
    end

endmodule

// File: rtl/mac_mul_stage.sv
// Module mac_mul_stage
// Second stage: sign-extends A and D by one bit, pre-adds them, multiplies
// by B and registers the full-width product. C and the decoded operation
// are delayed one stage so that they stay aligned with the product.
// Assumes signed operands from mac_in_stage.
module mac_mul_stage
    import mac_pkg::*;
#(
    parameter int A_W = 18,
    parameter int B_W = 18,
    parameter int C_W = 48,
    localparam int PRE_W = A_W + 1,
    localparam int PRD_W = PRE_W + B_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ce,
    input  logic [1:0]              op_d,
    input  logic signed [A_W-1:0]   a_d,
    input  logic signed [A_W-1:0]   d_d,
    input  logic signed [B_W-1:0]   b_d,
    input  logic signed [C_W-1:0]   c_d,
    output post_ctrl_t              ctrl_q,
    output logic signed [PRD_W-1:0] prod_q,
    output logic signed [C_W-1:0]   c_q
);

    logic signed [PRE_W-1:0] pre_sum;
    logic signed [PRD_W-1:0] prod_d;

    // Pre-add at one bit above the operand width, so the sum cannot overflow.
    always_comb begin
        pre_sum = PRE_W'(a_d) + PRE_W'(d_d);
        prod_d  = PRD_W'(pre_sum) * PRD_W'(b_d);
    end

    // Register the product with the aligned addend and the decoded control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= '0;
            c_q    <= '0;
            ctrl_q <= POST_CTRL_RESET;
        end else if (ce) begin
            prod_q <= prod_d;
            c_q    <= c_d;
            ctrl_q <= decode_op(op_d);
        end
    end

endmodule

// File: rtl/mac_post_stage.sv
// Module mac_post_stage
// Final stage: sign-extends the product to the result width, negates it
// when asked, adds the selected addend (zero, C or the registered result)
// and registers the result, which wraps at the result width.
// Assumes P_W >= C_W.
module mac_post_stage
    import mac_pkg::*;
#(
    parameter int PRD_W = 37,
    parameter int C_W   = 48,
    parameter int P_W   = 48
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ce,
    input  post_ctrl_t              ctrl,
    input  logic signed [PRD_W-1:0] prod,
    input  logic signed [C_W-1:0]   c_d,
    output logic signed [P_W-1:0]   p_q
);

    logic signed [P_W-1:0] prod_ext;
    logic signed [P_W-1:0] addend;
    logic signed [P_W-1:0] p_next;

    // Fit the product to the result width, widening or trimming as the widths require.
    generate
        if (P_W > PRD_W) begin : g_widen
            assign prod_ext = {{(P_W-PRD_W){prod[PRD_W-1]}}, prod};
        end else begin : g_trim
            assign prod_ext = prod[P_W-1:0];
        end
    endgenerate

    // Choose the addend and form the next result.
    always_comb begin
        unique case (ctrl.addend)
            ADDEND_C: addend = P_W'(c_d);
            ADDEND_P: addend = p_q;
            default:  addend = '0;
        endcase
        p_next = ctrl.neg_prod ? (addend - prod_ext) : (addend + prod_ext);
    end

    // Result and accumulator register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '0;
        end else if (ce) begin
            p_q <= p_next;
        end
    end

endmodule

// File: rtl/preadd_mac_slice.sv
// Module preadd_mac_slice
// Top of the three-stage signed pre-adder multiply-accumulate slice.
// Every input reaches p_out after three enabled edges. One synchronous
// active-low clear and one clock enable serve every register.
// Assumes all inputs are driven to known values.
module preadd_mac_slice
    import mac_pkg::*;
#(
    parameter int A_W = 18,
    parameter int B_W = 18,
    parameter int C_W = 48,
    parameter int P_W = 48,
    localparam int PRD_W = A_W + 1 + B_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ce,
    input  logic [1:0]            op_sel,
    input  logic signed [A_W-1:0] a_in,
    input  logic signed [A_W-1:0] d_in,
    input  logic signed [B_W-1:0] b_in,
    input  logic signed [C_W-1:0] c_in,
    output logic signed [P_W-1:0] p_out
);

    logic [1:0]              s1_op;
    logic signed [A_W-1:0]   s1_a;
    logic signed [A_W-1:0]   s1_d;
    logic signed [B_W-1:0]   s1_b;
    logic signed [C_W-1:0]   s1_c;
    post_ctrl_t              s2_ctrl;
    logic signed [PRD_W-1:0] s2_prod;
    logic signed [C_W-1:0]   s2_c;

    mac_in_stage #(.A_W(A_W), .B_W(B_W), .C_W(C_W)) u_in (
        .clk(clk), .rst_n(rst_n), .ce(ce),
        .op_in(op_sel), .a_in(a_in), .d_in(d_in), .b_in(b_in), .c_in(c_in),
        .op_q(s1_op), .a_q(s1_a), .d_q(s1_d), .b_q(s1_b), .c_q(s1_c)
    );

    mac_mul_stage #(.A_W(A_W), .B_W(B_W), .C_W(C_W)) u_mul (
        .clk(clk), .rst_n(rst_n), .ce(ce),
        .op_d(s1_op), .a_d(s1_a), .d_d(s1_d), .b_d(s1_b), .c_d(s1_c),
        .ctrl_q(s2_ctrl), .prod_q(s2_prod), .c_q(s2_c)
    );

    mac_post_stage #(.PRD_W(PRD_W), .C_W(C_W), .P_W(P_W)) u_post (
        .clk(clk), .rst_n(rst_n), .ce(ce),
        .ctrl(s2_ctrl), .prod(s2_prod), .c_d(s2_c),
        .p_q(p_out)
    );

endmodule

// File: rtl/preadd_mac_slice_chk.sv
// Module preadd_mac_slice_chk
// Port-level checker for preadd_mac_slice. It counts unbroken runs of
// enabled, non-cleared edges and checks each operation's result only once
// a full three-edge window has passed without a stall or a clear.
module preadd_mac_slice_chk #(
    parameter int A_W = 18,
    parameter int B_W = 18,
    parameter int C_W = 48,
    parameter int P_W = 48
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ce,
    input logic [1:0]            op_sel,
    input logic signed [A_W-1:0] a_in,
    input logic signed [A_W-1:0] d_in,
    input logic signed [B_W-1:0] b_in,
    input logic signed [C_W-1:0] c_in,
    input logic signed [P_W-1:0] p_out
);

    logic [1:0] run_cnt;

    // Length of the current run of enabled, non-cleared edges, held at 3.
    always_ff @(posedge clk) begin
        if (!rst_n || !ce) run_cnt <= 2'd0;
        else if (run_cnt != 2'd3) run_cnt <= run_cnt + 2'd1;
    end

    function automatic logic signed [P_W-1:0] f_prod(
        input logic signed [A_W-1:0] a,
        input logic signed [A_W-1:0] d,
        input logic signed [B_W-1:0] b);
        logic signed [P_W-1:0] s;
        s = P_W'(a) + P_W'(d);
        return s * P_W'(b);
    endfunction

    logic win;
    assign win = rst_n && ce && (run_cnt >= 2'd2);

    // R1 (and R6: the select is taken from the same capture edge as the operands)
    p_mac_c_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (win && $past(op_sel, 2) == 2'd0) |=>
        p_out == $past(f_prod($past(a_in, 2), $past(d_in, 2), $past(b_in, 2)) + P_W'($past(c_in, 2))));

    p_accum_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (win && $past(op_sel, 2) == 2'd1) |=>
        p_out == $past(p_out) + $past(f_prod($past(a_in, 2), $past(d_in, 2), $past(b_in, 2))));

    p_mul_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (win && $past(op_sel, 2) == 2'd2) |=>
        p_out == $past(f_prod($past(a_in, 2), $past(d_in, 2), $past(b_in, 2))));

    p_c_minus_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (win && $past(op_sel, 2) == 2'd3) |=>
        p_out == $past(P_W'($past(c_in, 2)) - f_prod($past(a_in, 2), $past(d_in, 2), $past(b_in, 2))));

    p_clear_r7: assert property (@(posedge clk)
        !rst_n |=> p_out == '0);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(p_out));

endmodule

bind preadd_mac_slice preadd_mac_slice_chk #(
    .A_W(A_W), .B_W(B_W), .C_W(C_W), .P_W(P_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ce(ce), .op_sel(op_sel),
    .a_in(a_in), .d_in(d_in), .b_in(b_in), .c_in(c_in), .p_out(p_out)
);

// File: tb/preadd_mac_slice_bench.sv
// Bench for preadd_mac_slice: a behavioural queue model, compared on every cycle.
module preadd_mac_slice_bench;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               ce = 1'b1;
    logic [1:0]         op_sel = 2'd0;
    logic signed [17:0] a_in = '0;
    logic signed [17:0] d_in = '0;
    logic signed [17:0] b_in = '0;
    logic signed [47:0] c_in = '0;
    logic signed [47:0] p_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string phase_tag = "R7";

    always #4 clk = ~clk;

    preadd_mac_slice u_preadd_mac_slice (
        .clk(clk), .rst_n(rst_n), .ce(ce), .op_sel(op_sel),
        .a_in(a_in), .d_in(d_in), .b_in(b_in), .c_in(c_in), .p_out(p_out)
    );

    typedef struct {
        int     op;
        longint a, d, b, c;
    } ent_t;

    ent_t   pend[$];
    longint m_p = 0;
    string  m_tag = "R7";

    function automatic longint wrap48(input longint v);
        return (v <<< 16) >>> 16;
    endfunction

    // Reference model: a request applied on one enabled edge lands on the third.
    always @(posedge clk) begin
        ent_t e;
        ent_t z;
        longint prod;
        z = '{op: 0, a: 0, d: 0, b: 0, c: 0};
        if (!rst_n) begin
            m_p = 0;
            pend.delete();
            pend.push_back(z);
            pend.push_back(z);
            m_tag = "R7";
        end else if (ce) begin
            e = '{op: int'(op_sel), a: longint'(a_in), d: longint'(d_in),
                  b: longint'(b_in), c: longint'(c_in)};
            pend.push_back(e);
            e = pend.pop_front();
            prod = e.b * (e.a + e.d);
            case (e.op)
                0: begin m_p = wrap48(prod + e.c); m_tag = "R1"; end
                1: begin m_p = wrap48(m_p + prod); m_tag = "R2"; end
                2: begin m_p = wrap48(prod);       m_tag = "R3"; end
                default: begin m_p = wrap48(e.c - prod); m_tag = "R4"; end
            endcase
        end else begin
            m_tag = "R8";
        end
    end

    // Compare the output with the model away from the active edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (p_out !== 48'(m_p)) begin
            errors++;
            $display("FAIL %s %s: p_out=%0d expected=%0d", m_tag, phase_tag, p_out, m_p);
        end
    endtask

    task automatic drive(input int op, input longint a, input longint d,
                         input longint b, input longint c);
        op_sel = 2'(op);
        a_in = 18'(a);
        d_in = 18'(d);
        b_in = 18'(b);
        c_in = 48'(c);
    endtask

    // Watchdog: a hung run counts as a failed check and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R7: clear with ce high, then check that the flushed pipeline drains zeros.
        phase_tag = "R7";
        drive(1, 100, 200, 300, 5);
        repeat (3) step();
        @(negedge clk);
        rst_n = 1'b1;
        drive(0, 0, 0, 0, 0);
        repeat (2) step();

        // R1 to R4, each select code in turn.
        phase_tag = "R1";
        drive(0, 1000, -7, 33, 123456); step();
        phase_tag = "R3";
        drive(2, -500, 250, -91, 999); step();
        phase_tag = "R4";
        drive(3, 17, 4, 1234, -77777); step();
        phase_tag = "R2";
        drive(1, 3, 4, 5, 0); repeat (6) step();

        // R5: pre-add extremes, where an 18-bit sum would overflow.
        phase_tag = "R5";
        drive(2, -131072, -131072, -131072, 0); step();
        drive(2, 131071, 131071, -131072, 0); step();
        drive(0, 131071, 131071, 131071, 0); step();
        drive(3, -131072, -131072, 131071, 0); repeat (3) step();

        // R9: wrap past the 48-bit range.
        phase_tag = "R9";
        drive(0, 1000, 0, 1000, 64'h7FFF_FFFF_FFFF); step();
        drive(3, 1000, 0, 1000, -(64'sd1 <<< 47)); step();
        drive(1, 131071, 131071, -131072, 0); repeat (200) step();

        // R8: hold under ce low while the inputs keep changing.
        phase_tag = "R8";
        drive(1, 11, 22, 33, 44); step();
        ce = 1'b0;
        for (int i = 0; i < 6; i++) begin
            drive(i % 4, i * 97, -i, i + 5, i * 1000);
            step();
        end
        ce = 1'b1;
        repeat (4) step();

        // R6: the select changes every cycle, with random stalls and rare clears.
        phase_tag = "R6";
        for (int i = 0; i < 3000; i++) begin
            drive(int'($urandom_range(0, 3)),
                  longint'($signed(18'($urandom))), longint'($signed(18'($urandom))),
                  longint'($signed(18'($urandom))),
                  longint'($signed({16'($urandom), 32'($urandom)})));
            ce = ($urandom_range(0, 4) != 0);
            rst_n = ($urandom_range(0, 199) != 0);
            step();
        end
        rst_n = 1'b1;
        ce = 1'b1;
        repeat (4) step();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule